// File: doc/BRIEF.md
# Folded Radix-4 Inverse FFT Engine

This block turns a frame of 64 complex fixed-point samples into their 64-point inverse discrete Fourier transform, scaled by 1/64. It has a single radix-4 butterfly datapath. A stage counter (0 to 2) and a group counter (0 to 15) drive that one datapath through all 48 butterflies of the transform. Wide multiplexers pick each group of four operands from a 64-entry working memory. The four results go back to the same four entries. On the last group of a stage, the whole memory is rewritten through a fixed stride permutation, so that it becomes the input of the next stage.

Samples stream in one per beat on a valid/ready port and results stream out the same way. The input port is ready only while the engine is idle and collecting a frame. During the 48 compute cycles and while results are being drained, `in_ready` stays low and any offered beat is left untouched. On the output side, the consumer may hold `out_ready` low for as long as it wants: `out_valid`, `out_re` and `out_im` then hold their values, and nothing is skipped. Once the 64th result has been accepted, the engine goes back to idle.

The twiddle factors come from a quarter-wave cosine table in Q1.15. The table is selected by stage and group index. Products are rounded back to Q1.15, and every butterfly output is divided by four with rounding and saturation. After three stages this gives the overall 1/64 gain.

Top module: `fold4_ifft`

## Requirements
- R1: A synchronous active-high `rst` puts the engine in idle at any point, including in the middle of a computation: `in_ready`=1 and `out_valid`=0 on the first cycle after `rst` falls.
- R2: A beat is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Beat n (n = 0..63) of a frame is sample x[n]. After the 64th accepted beat, `in_ready` is 0 on the next cycle.
- R3: While `in_ready` is 0, the values on `in_valid`, `in_re` and `in_im` have no effect on the result or on its timing.
- R4: `out_valid` first rises exactly 48 cycles after the edge that accepted the 64th input beat, one cycle per butterfly.
- R5: Output beat k (k = 0..63, natural order) carries X[k] = (1/64)·Σn x[n]·e^{+j2πnk/64}. Each of the real and imaginary parts is within ±12 LSB of the ideal value when no intermediate result saturates.
- R6: While `out_valid`=1 and `out_ready`=0, on the next cycle `out_valid` is still 1 and `out_re`/`out_im` are unchanged.
- R7: After the 64th output beat is accepted, the next cycle shows `in_ready`=1 and `out_valid`=0, and a new frame may be loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Engine idle and taking samples |
| in_re | input | DW | Input real part, signed Q1.15 |
| in_im | input | DW | Input imaginary part, signed Q1.15 |
| out_valid | output | 1 | Result sample presented |
| out_ready | input | 1 | Consumer takes the presented result |
| out_re | output | DW | Result real part, signed |
| out_im | output | DW | Result imaginary part, signed |

## Verification
The assertions take `rst` to be synchronous. They allow `in_valid` and `out_ready` to take any value on any cycle, so the handshake checks hold whatever the neighbours do. The numeric checks rely on the input amplitudes being small enough that no butterfly output saturates. The stimulus stays within ±20000 per component, and the pseudo-random frames stay within ±8191. Under those limits the error against the ideal transform comes from rounding alone. The stimulus also keeps `in_valid` high with junk data during one computation, stalls the consumer in the middle of a drain, and pulls reset while the butterfly sequence is running.

// File: rtl/fold4_ifft_pkg.sv
package fold4_ifft_pkg;
  localparam int PTS   = 64;
  localparam int NGRP  = 16;
  localparam int NSTG  = 3;
  localparam int IDXW  = $clog2(PTS);
  localparam int GRPW  = $clog2(NGRP);
  localparam int STGW  = 2;
  localparam int TW    = 16;

  typedef enum logic [1:0] {PH_LOAD, PH_RUN, PH_DRAIN} phase_t;

  // base-4 digit reversal: memory slot that receives input sample n
  function automatic logic [IDXW-1:0] digrev4(input logic [IDXW-1:0] n);
    return {n[1:0], n[3:2], n[5:4]};
  endfunction

  // inter-stage stride map: slot p takes the element at (p mod 16)*4 + p/16
  function automatic logic [IDXW-1:0] perm_src(input logic [IDXW-1:0] p);
    return {p[3:0], p[5:4]};
  endfunction

  // twiddle exponent (units of 2*pi/64) for leg n of group g in stage s
  function automatic logic [IDXW-1:0] tw_exp(input logic [STGW-1:0] s,
                                             input logic [GRPW-1:0] g,
                                             input logic [1:0] n);
    logic [IDXW-1:0] base;
    case (s)
      2'd1:    base = {g[3:2], 2'b00};
      2'd2:    base = {2'b00, g};
      default: base = '0;
    endcase
    return base * {4'b0000, n};
  endfunction

  // cos(2*pi*r/64) in Q1.15 for r = 0..16
  function automatic logic signed [TW-1:0] qcos(input logic [4:0] r);
    case (r)
      5'd0:  return 16'sd32767;  5'd1:  return 16'sd32609;
      5'd2:  return 16'sd32138;  5'd3:  return 16'sd31356;
      5'd4:  return 16'sd30273;  5'd5:  return 16'sd28898;
      5'd6:  return 16'sd27245;  5'd7:  return 16'sd25330;
      5'd8:  return 16'sd23170;  5'd9:  return 16'sd20787;
      5'd10: return 16'sd18205;  5'd11: return 16'sd15446;
      5'd12: return 16'sd12540;  5'd13: return 16'sd9512;
      5'd14: return 16'sd6393;   5'd15: return 16'sd3212;
      default: return 16'sd0;
    endcase
  endfunction

  function automatic logic signed [TW-1:0] tw_cos(input logic [IDXW-1:0] e);
    logic [4:0] r, rc;
    r  = {1'b0, e[3:0]};
    rc = 5'd16 - r;
    case (e[5:4])
      2'd0:    return qcos(r);
      2'd1:    return -qcos(rc);
      2'd2:    return -qcos(r);
      default: return qcos(rc);
    endcase
  endfunction

  function automatic logic signed [TW-1:0] tw_sin(input logic [IDXW-1:0] e);
    logic [4:0] r, rc;
    r  = {1'b0, e[3:0]};
    rc = 5'd16 - r;
    case (e[5:4])
      2'd0:    return qcos(rc);
      2'd1:    return qcos(r);
      2'd2:    return -qcos(rc);
      default: return -qcos(r);
    endcase
  endfunction
endpackage

// File: rtl/fold4_ifft_ctrl.sv
module fold4_ifft_ctrl
  import fold4_ifft_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            out_ready,
  output logic            in_ready,
  output logic            out_valid,
  output logic            load_fire,
  output logic            run_en,
  output logic            stage_last,
  output logic [IDXW-1:0] load_idx,
  output logic [IDXW-1:0] out_idx,
  output logic [STGW-1:0] stage,
  output logic [GRPW-1:0] grp
);
  phase_t ph;

  assign in_ready   = (ph == PH_LOAD);
  assign out_valid  = (ph == PH_DRAIN);
  assign run_en     = (ph == PH_RUN);
  assign load_fire  = in_ready && in_valid;
  assign stage_last = run_en && (grp == GRPW'(NGRP - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_LOAD;
      load_idx <= '0;
      out_idx  <= '0;
      stage    <= '0;
      grp      <= '0;
    end else begin
      case (ph)
        PH_LOAD: if (in_valid) begin
          load_idx <= load_idx + 1'b1;
          if (load_idx == IDXW'(PTS - 1)) begin
            ph    <= PH_RUN;
            stage <= '0;
            grp   <= '0;
          end
        end
        PH_RUN: begin
          grp <= grp + 1'b1;
          if (grp == GRPW'(NGRP - 1)) begin
            if (stage == STGW'(NSTG - 1)) begin
              ph      <= PH_DRAIN;
              out_idx <= '0;
            end else begin
              stage <= stage + 1'b1;
            end
          end
        end
        PH_DRAIN: if (out_ready) begin
          out_idx <= out_idx + 1'b1;
          if (out_idx == IDXW'(PTS - 1)) ph <= PH_LOAD;
        end
        default: ph <= PH_LOAD;
      endcase
    end
  end

  AST_LOAD_END: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && load_idx == IDXW'(PTS - 1)) |=> !in_ready); // R2
  AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && load_idx == IDXW'(PTS - 1)) |=> (run_en && stage == '0 && grp == '0)); // R4
  AST_RUN_DONE: assert property (@(posedge clk) disable iff (rst)
    (run_en && stage == STGW'(NSTG - 1) && grp == GRPW'(NGRP - 1)) |=> (out_valid && out_idx == '0)); // R4
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(load_idx)); // R3
  AST_DRAIN_END: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_idx == IDXW'(PTS - 1)) |=> (in_ready && !out_valid)); // R7
endmodule

// File: rtl/fold4_ifft_twid.sv
module fold4_ifft_twid
  import fold4_ifft_pkg::*;
(
  input  logic [STGW-1:0]        stage,
  input  logic [GRPW-1:0]        grp,
  output logic signed [TW-1:0]   k_re [4],
  output logic signed [TW-1:0]   k_im [4]
);
  for (genvar n = 0; n < 4; n++) begin : g_leg
    logic [IDXW-1:0] ex;
    assign ex      = tw_exp(stage, grp, 2'(n));
    assign k_re[n] = tw_cos(ex);
    assign k_im[n] = tw_sin(ex);
  end
endmodule

// File: rtl/fold4_ifft_bfly.sv
module fold4_ifft_bfly
  import fold4_ifft_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] t_re [4],
  input  logic signed [DW-1:0] t_im [4],
  input  logic signed [TW-1:0] k_re [4],
  input  logic signed [TW-1:0] k_im [4],
  output logic signed [DW-1:0] z_re [4],
  output logic signed [DW-1:0] z_im [4]
);
  localparam int PW   = DW + TW + 1;
  localparam int MW   = DW + 2;
  localparam int YW   = MW + 2;
  localparam int ZW   = YW + 1;
  localparam int RND  = 1 << (TW - 2);
  localparam int SMAX = (1 << (DW - 1)) - 1;
  localparam int SMIN = -(1 << (DW - 1));

  logic signed [MW-1:0] m_re [4], m_im [4];
  logic signed [YW-1:0] y_re [4], y_im [4];
  logic signed [YW-1:0] d_re, d_im;
  logic signed [ZW-1:0] w_re [4], w_im [4];

  function automatic logic signed [DW-1:0] quarter_sat(input logic signed [ZW-1:0] v);
    logic signed [ZW-1:0] s;
    s = (v + ZW'(2)) >>> 2;
    if (s > ZW'(SMAX)) return DW'(SMAX);
    if (s < ZW'(SMIN)) return DW'(SMIN);
    return DW'(s);
  endfunction

  // twiddle products m_n = k_n * t_n, rounded back to Q1.15 scale
  for (genvar n = 0; n < 4; n++) begin : g_mul
    logic signed [PW-1:0] rr, ii, ri, ir, p_re, p_im;
    assign rr   = PW'(t_re[n]) * PW'(k_re[n]);
    assign ii   = PW'(t_im[n]) * PW'(k_im[n]);
    assign ri   = PW'(t_re[n]) * PW'(k_im[n]);
    assign ir   = PW'(t_im[n]) * PW'(k_re[n]);
    assign p_re = rr - ii;
    assign p_im = ri + ir;
    assign m_re[n] = MW'((p_re + PW'(RND)) >>> (TW - 1));
    assign m_im[n] = MW'((p_im + PW'(RND)) >>> (TW - 1));
  end

  // first level; the odd difference is rotated by +j: (a+jb)j = -b+ja
  assign y_re[0] = YW'(m_re[0]) + YW'(m_re[2]);
  assign y_im[0] = YW'(m_im[0]) + YW'(m_im[2]);
  assign y_re[1] = YW'(m_re[0]) - YW'(m_re[2]);
  assign y_im[1] = YW'(m_im[0]) - YW'(m_im[2]);
  assign y_re[2] = YW'(m_re[1]) + YW'(m_re[3]);
  assign y_im[2] = YW'(m_im[1]) + YW'(m_im[3]);
  assign d_re    = YW'(m_re[1]) - YW'(m_re[3]);
  assign d_im    = YW'(m_im[1]) - YW'(m_im[3]);
  assign y_re[3] = -d_im;
  assign y_im[3] = d_re;

  // second level
  assign w_re[0] = ZW'(y_re[0]) + ZW'(y_re[2]);
  assign w_im[0] = ZW'(y_im[0]) + ZW'(y_im[2]);
  assign w_re[1] = ZW'(y_re[1]) + ZW'(y_re[3]);
  assign w_im[1] = ZW'(y_im[1]) + ZW'(y_im[3]);
  assign w_re[2] = ZW'(y_re[0]) - ZW'(y_re[2]);
  assign w_im[2] = ZW'(y_im[0]) - ZW'(y_im[2]);
  assign w_re[3] = ZW'(y_re[1]) - ZW'(y_re[3]);
  assign w_im[3] = ZW'(y_im[1]) - ZW'(y_im[3]);

  for (genvar n = 0; n < 4; n++) begin : g_out
    assign z_re[n] = quarter_sat(w_re[n]);
    assign z_im[n] = quarter_sat(w_im[n]);
  end
endmodule

// File: rtl/fold4_ifft.sv
module fold4_ifft
  import fold4_ifft_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  logic                 load_fire, run_en, stage_last;
  logic [IDXW-1:0]      load_idx, out_idx, load_pos;
  logic [STGW-1:0]      stage;
  logic [GRPW-1:0]      grp;

  logic signed [DW-1:0] mem_re [PTS], mem_im [PTS];
  logic signed [DW-1:0] upd_re [PTS], upd_im [PTS];
  logic signed [DW-1:0] nxt_re [PTS], nxt_im [PTS];
  logic signed [DW-1:0] t_re [4], t_im [4], z_re [4], z_im [4];
  logic signed [TW-1:0] k_re [4], k_im [4];

  fold4_ifft_ctrl u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .load_fire(load_fire),
    .run_en(run_en), .stage_last(stage_last), .load_idx(load_idx),
    .out_idx(out_idx), .stage(stage), .grp(grp)
  );

  fold4_ifft_twid u_twid (.stage(stage), .grp(grp), .k_re(k_re), .k_im(k_im));

  fold4_ifft_bfly #(.DW(DW)) u_bfly (
    .t_re(t_re), .t_im(t_im), .k_re(k_re), .k_im(k_im), .z_re(z_re), .z_im(z_im)
  );

  // operand selection: four 16-way multiplexers
  for (genvar n = 0; n < 4; n++) begin : g_opnd
    assign t_re[n] = mem_re[{grp, 2'(n)}];
    assign t_im[n] = mem_im[{grp, 2'(n)}];
  end

  // result routing: the active group is replaced in place
  always_comb begin
    for (int e = 0; e < PTS; e++) begin
      if (IDXW'(e) >> 2 == IDXW'(grp)) begin
        upd_re[e] = z_re[e % 4];
        upd_im[e] = z_im[e % 4];
      end else begin
        upd_re[e] = mem_re[e];
        upd_im[e] = mem_im[e];
      end
    end
  end

  // the last group of a stage writes the whole memory through the stride map
  always_comb begin
    for (int e = 0; e < PTS; e++) begin
      nxt_re[e] = stage_last ? upd_re[perm_src(IDXW'(e))] : upd_re[e];
      nxt_im[e] = stage_last ? upd_im[perm_src(IDXW'(e))] : upd_im[e];
    end
  end

  assign load_pos = digrev4(load_idx);

  always_ff @(posedge clk) begin
    for (int e = 0; e < PTS; e++) begin
      if (load_fire && load_pos == IDXW'(e)) begin
        mem_re[e] <= in_re;
        mem_im[e] <= in_im;
      end else if (run_en) begin
        mem_re[e] <= nxt_re[e];
        mem_im[e] <= nxt_im[e];
      end
    end
  end

  assign out_re = mem_re[out_idx];
  assign out_im = mem_im[out_idx];

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im))); // R6
endmodule

// File: tb/fold4_ifft_tb_top.sv
`timescale 1ns/1ps
module fold4_ifft_tb_top;
  localparam int DW  = 16;
  localparam real TOL = 12.0;
  localparam real PI  = 3.14159265358979;

  // stimulus table: {kind, pos/seed, amp_re, amp_im}
  // kind 0 impulse at pos, 1 constant, 2 tone at frequency pos, 3 pseudo-random
  // expected result per entry is the scaled inverse DFT of the generated frame
  localparam logic [39:0] CASES [7] = '{
    {2'd0, 6'd0,  16'd16000, 16'd0},
    {2'd0, 6'd5,  16'd12000, 16'd58536},
    {2'd1, 6'd0,  16'd20000, 16'd62536},
    {2'd2, 6'd3,  16'd15000, 16'd0},
    {2'd2, 6'd37, 16'd9000,  16'd0},
    {2'd3, 6'd1,  16'd0,     16'd0},
    {2'd3, 6'd9,  16'd0,     16'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic signed [DW-1:0] in_re = '0, in_im = '0, out_re, out_im;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int xr [64], xi [64], yr [64], yi [64];

  always #2.5 clk = ~clk;

  fold4_ifft #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic build(input int c);
    logic [1:0] kind;
    int pos, ar, ai, s;
    real th;
    kind = CASES[c][39:38];
    pos  = int'(CASES[c][37:32]);
    ar   = int'(signed'(CASES[c][31:16]));
    ai   = int'(signed'(CASES[c][15:0]));
    s    = pos * 7919 + 17;
    for (int n = 0; n < 64; n++) begin
      case (kind)
        2'd0: begin xr[n] = (n == pos) ? ar : 0; xi[n] = (n == pos) ? ai : 0; end
        2'd1: begin xr[n] = ar; xi[n] = ai; end
        2'd2: begin
          th = 2.0 * PI * real'(pos * n) / 64.0;
          xr[n] = rnd(real'(ar) * $cos(th));
          xi[n] = rnd(-real'(ar) * $sin(th));
        end
        default: begin
          s = s * 1103515245 + 12345;
          xr[n] = ((s >>> 8) % 8192);
          s = s * 1103515245 + 12345;
          xi[n] = ((s >>> 8) % 8192);
        end
      endcase
    end
  endtask

  task automatic load_frame();
    for (int n = 0; n < 64; n++) begin
      in_valid = 1'b1;
      in_re = DW'(xr[n]);
      in_im = DW'(xi[n]);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic receive(input bit stall);
    logic signed [DW-1:0] hr, hi;
    bit ok;
    for (int k = 0; k < 64; k++) begin
      while (!out_valid) @(negedge clk);
      if (stall && k == 10) begin
        out_ready = 1'b0;
        hr = out_re; hi = out_im; ok = 1'b1;
        repeat (4) begin
          @(negedge clk);
          ok &= out_valid && out_re == hr && out_im == hi;
        end
        chk(ok, "R6", "result held under back-pressure", int'(out_re), int'(hr));
        out_ready = 1'b1;
      end
      yr[k] = int'(out_re);
      yi[k] = int'(out_im);
      @(negedge clk);
    end
  endtask

  task automatic compare(input int c, input string tag);
    real er, ei, th, worst, d;
    int wk, wer, wei;
    worst = -1.0; wk = 0; wer = 0; wei = 0;
    for (int k = 0; k < 64; k++) begin
      er = 0.0; ei = 0.0;
      for (int n = 0; n < 64; n++) begin
        th = 2.0 * PI * real'((n * k) % 64) / 64.0;
        er += real'(xr[n]) * $cos(th) - real'(xi[n]) * $sin(th);
        ei += real'(xr[n]) * $sin(th) + real'(xi[n]) * $cos(th);
      end
      er = er / 64.0; ei = ei / 64.0;
      d = (real'(yr[k]) > er) ? real'(yr[k]) - er : er - real'(yr[k]);
      if (d > worst) begin worst = d; wk = k; wer = rnd(er); wei = rnd(ei); end
      d = (real'(yi[k]) > ei) ? real'(yi[k]) - ei : ei - real'(yi[k]);
      if (d > worst) begin worst = d; wk = k; wer = rnd(er); wei = rnd(ei); end
    end
    n_chk++;
    if (worst > TOL) begin
      n_fail++;
      $display("FAIL %s case %0d k=%0d actual=(%0d,%0d) expected=(%0d,%0d)",
               tag, c, wk, yr[wk], yi[wk], wer, wei);
    end
  endtask

  task automatic run_case(input int c, input bit junk, input bit stall);
    int cnt;
    build(c);
    load_frame();
    chk(!in_ready, "R2", "in_ready after 64th beat", int'(in_ready), 0);
    if (junk) begin
      in_valid = 1'b1; in_re = 16'sh7fff; in_im = -16'sh8000;
    end
    cnt = 0;
    while (!out_valid && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    in_valid = 1'b0;
    chk(cnt == 48, "R4", "cycles from last accept to out_valid", cnt, 48);
    receive(stall);
    chk(in_ready && !out_valid, "R7", "idle after 64th result",
        int'({in_ready, out_valid}), 2);
    compare(c, junk ? "R3/R5" : "R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready && !out_valid, "R1", "state after reset", int'({in_ready, out_valid}), 2);

    // main table walk
    for (int c = 0; c < 7; c++) run_case(c, c == 3, c == 1);

    // reset in the middle of the butterfly sequence
    build(4);
    load_frame();
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready && !out_valid, "R1", "state after reset during compute",
        int'({in_ready, out_valid}), 2);

    // a full frame works after the interrupted one
    run_case(5, 1'b0, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule